// File: doc/BRIEF.md
# Open-String Fault Latch and Diagnostic Controller

This block is the digital decision stage behind an eight-channel constant-current LED driver. Each channel has an analog comparator that says its sensed current has fallen below half of the target. The block filters those flags and decides two things: whether every channel drive must be forced off, and whether the open-drain diagnostic line is released (high = fault) or held low (normal).

A pin-level select chooses between two policies. In latching mode, a confirmed open on any channel shuts all eight outputs off and keeps them off. In reporting mode, the outputs keep running and only the diagnostic line reports. An open is only believed while the channel is actively driven, so under PWM dimming the report pulses with the on-time. Detection is held off until the supply is above the open-load threshold. Channels found grounded during power-up are masked as unused. Three events release the latch: the diagnostic line being pulled below its reset level, a toggle of the global enable, or an undervoltage.

Global flags for reference current limit, overvoltage setback, thermal shutdown and an open daisy-chain line also release the diagnostic line. Thermal shutdown and an open chain line additionally force all outputs off.

Top module: `led_fault_guard`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `kill_all` = 0, `diag_pull_low` = 1 and `unused_mask` = 0.
- R2: A channel's open flag is accepted only after DEB_CYCLES clock edges (default 4) at which both its open flag and its drive-active input are high. A low open flag while driven restarts the count. Edges at which the drive is inactive neither advance nor restart the count. Outputs react on the edge after the DEB_CYCLES-th counted edge.
- R3: No open is accepted, and all counts are cleared, while `supply_ok` is low or `uvlo` is high.
- R4: While `supply_ok` is low, `unused_mask` follows `pin_grounded` one edge later. While `supply_ok` is high, it is frozen. A channel whose mask bit is 1 never contributes to a fault.
- R5: With `latch_sel_n` = 0, an accepted open sets a latch. The latch drives `kill_all` = 1 and `diag_pull_low` = 0, and both stay that way after the open flag drops.
- R6: With `latch_sel_n` = 1, an accepted open never raises `kill_all`. `diag_pull_low` is 0 only on edges following cycles where an accepted channel is actively driven.
- R7: A rising edge on `diag_rst_sense` clears the latch and all counts. Holding it high gives no further clearing, so an open that is still present is latched again DEB_CYCLES+1 edges later.
- R8: Any change of level on `enable_n` clears the latch and all counts.
- R9: `uvlo` high clears the latch.
- R10: `ref_ilim`, `ov_setback`, `therm_sd` and `chain_open` each give `diag_pull_low` = 0 on the next edge. Only `therm_sd` and `chain_open` give `kill_all` = 1, in both modes, and without latching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| open_det | input | N_CH | Per-channel comparator: current below half of target |
| drv_active | input | N_CH | Per-channel drive currently on (PWM on-phase or DC) |
| pin_grounded | input | N_CH | Per-channel output sensed at ground |
| supply_ok | input | 1 | Supply above open-load enable threshold |
| uvlo | input | 1 | Supply below undervoltage lockout |
| latch_sel_n | input | 1 | 0 = latch all outputs off on open, 1 = report only |
| enable_n | input | 1 | Global enable, low = on |
| diag_rst_sense | input | 1 | Diagnostic line sensed below its reset level |
| ref_ilim | input | 1 | Reference current limit active |
| ov_setback | input | 1 | Overvoltage current setback active |
| therm_sd | input | 1 | Thermal shutdown |
| chain_open | input | 1 | Daisy-chain output line found open |
| kill_all | output | 1 | Force every channel drive off |
| diag_pull_low | output | 1 | 1 = hold diagnostic line low (normal), 0 = release (fault) |
| unused_mask | output | N_CH | Channels marked unused at power-up |

## Verification
The bench probes the debounce edge: a flag interrupted one edge short of acceptance must not fault, and edges with the drive off must hold the count rather than restart it. A design that counted every clock, or reset on drive-off, would latch too early or never. It holds the diagnostic-reset sense high on a still-present open and expects a relatch. A level-sensitive clear would keep the outputs on indefinitely. It toggles drive under reporting mode to show the report following the on-phase, and it grounds one channel at power-up to show that its opens are ignored while its neighbours still latch.

// File: rtl/fg_pkg.sv
package fg_pkg;
  typedef struct packed {
    logic ilim;
    logic setback;
    logic thermal;
    logic chain_open;
  } glob_flt_t;

  function automatic logic flt_release(glob_flt_t f);
    return f.ilim | f.setback | f.thermal | f.chain_open;
  endfunction

  function automatic logic flt_kill(glob_flt_t f);
    return f.thermal | f.chain_open;
  endfunction
endpackage

// File: rtl/fg_chan_filter.sv
module fg_chan_filter #(
  parameter int DEB_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic open_i,
  input  logic drive_i,
  input  logic arm_i,
  input  logic clr_i,
  output logic accepted_o
);
  localparam int CW = $clog2(DEB_CYCLES + 1);
  localparam logic [CW-1:0] LIM = CW'(DEB_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr_i || !arm_i) begin
      cnt <= '0;
    end else if (drive_i) begin
      if (!open_i)          cnt <= '0;
      else if (cnt != LIM)  cnt <= cnt + 1'b1;
    end
  end

  assign accepted_o = (cnt == LIM);

  // R3: a disarmed channel has an empty count on the next cycle
  p_disarm_r3: assert property (@(posedge clk) disable iff (rst)
    !arm_i |=> (cnt == '0));
  // R2: inactive drive holds the count
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (arm_i && !clr_i && !drive_i) |=> $stable(cnt));
  // R2: an accepted flag that persists stays accepted
  p_keep_r2: assert property (@(posedge clk) disable iff (rst)
    (accepted_o && arm_i && !clr_i && drive_i && open_i) |=> accepted_o);
endmodule

// File: rtl/fg_unused_map.sv
module fg_unused_map #(
  parameter int N_CH = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            supply_ok,
  input  logic [N_CH-1:0] pin_grounded,
  output logic [N_CH-1:0] unused_o
);
  always_ff @(posedge clk) begin
    if (rst)             unused_o <= '0;
    else if (!supply_ok) unused_o <= pin_grounded;
  end

  // R4: frozen once the supply is up
  p_freeze_r4: assert property (@(posedge clk) disable iff (rst)
    supply_ok |=> $stable(unused_o));
  // R4: tracks the grounded sense during power-up
  p_track_r4: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> (unused_o == $past(pin_grounded)));
endmodule

// File: rtl/fg_latch_ctl.sv
module fg_latch_ctl (
  input  logic clk,
  input  logic rst,
  input  logic latch_sel_n,
  input  logic any_open,
  input  logic enable_n,
  input  logic sense,
  input  logic uvlo,
  output logic clr_o,
  output logic lat_nxt_o
);
  logic en_q, sense_q, lat_q;

  // edge references follow their inputs even in reset, so no false edge
  always_ff @(posedge clk) begin
    en_q    <= enable_n;
    sense_q <= sense;
  end

  assign clr_o     = uvlo | (enable_n ^ en_q) | (sense & ~sense_q);
  assign lat_nxt_o = clr_o ? 1'b0 : (lat_q | (~latch_sel_n & any_open));

  always_ff @(posedge clk) begin
    if (rst) lat_q <= 1'b0;
    else     lat_q <= lat_nxt_o;
  end

  // R5: the latch holds while no clear source is present
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (lat_q && !uvlo && $stable(enable_n) && !$rose(sense)) |=> lat_q);
  // R6: report mode never sets the latch
  p_report_r6: assert property (@(posedge clk) disable iff (rst)
    (latch_sel_n && !lat_q) |=> !lat_q);
  // R7: rising reset sense clears
  p_sense_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(sense) |=> !lat_q);
  // R8: an enable toggle clears
  p_enable_r8: assert property (@(posedge clk) disable iff (rst)
    (enable_n != $past(enable_n)) |=> !lat_q);
  // R9: undervoltage clears
  p_uvlo_r9: assert property (@(posedge clk) disable iff (rst)
    uvlo |=> !lat_q);
endmodule

// File: rtl/led_fault_guard.sv
module led_fault_guard
  import fg_pkg::*;
#(
  parameter int N_CH       = 8,
  parameter int DEB_CYCLES = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_CH-1:0] open_det,
  input  logic [N_CH-1:0] drv_active,
  input  logic [N_CH-1:0] pin_grounded,
  input  logic            supply_ok,
  input  logic            uvlo,
  input  logic            latch_sel_n,
  input  logic            enable_n,
  input  logic            diag_rst_sense,
  input  logic            ref_ilim,
  input  logic            ov_setback,
  input  logic            therm_sd,
  input  logic            chain_open,
  output logic            kill_all,
  output logic            diag_pull_low,
  output logic [N_CH-1:0] unused_mask
);
  logic [N_CH-1:0] accepted;
  logic            clr, lat_nxt, live_open, kill_d, release_d;
  glob_flt_t       gflt;

  assign gflt = '{ilim: ref_ilim, setback: ov_setback,
                  thermal: therm_sd, chain_open: chain_open};

  fg_unused_map #(.N_CH(N_CH)) u_unused (
    .clk(clk), .rst(rst), .supply_ok(supply_ok),
    .pin_grounded(pin_grounded), .unused_o(unused_mask)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    fg_chan_filter #(.DEB_CYCLES(DEB_CYCLES)) u_filt (
      .clk(clk), .rst(rst),
      .open_i(open_det[i]), .drive_i(drv_active[i]),
      .arm_i(supply_ok & ~uvlo & ~unused_mask[i]),
      .clr_i(clr), .accepted_o(accepted[i])
    );
  end

  fg_latch_ctl u_latch (
    .clk(clk), .rst(rst), .latch_sel_n(latch_sel_n),
    .any_open(|accepted), .enable_n(enable_n),
    .sense(diag_rst_sense), .uvlo(uvlo),
    .clr_o(clr), .lat_nxt_o(lat_nxt)
  );

  assign live_open = (|(accepted & drv_active)) & ~clr;
  assign kill_d    = lat_nxt | flt_kill(gflt);
  assign release_d = lat_nxt | live_open | flt_release(gflt);

  always_ff @(posedge clk) begin
    if (rst) begin
      kill_all      <= 1'b0;
      diag_pull_low <= 1'b1;
    end else begin
      kill_all      <= kill_d;
      diag_pull_low <= ~release_d;
    end
  end

  // R10: thermal shutdown always forces the outputs off
  p_thermal_r10: assert property (@(posedge clk) disable iff (rst)
    therm_sd |=> kill_all);
  // R10: reporting-only flags release the diagnostic line
  p_release_r10: assert property (@(posedge clk) disable iff (rst)
    (ref_ilim || ov_setback) |=> !diag_pull_low);
  // R5: outputs are never killed silently
  p_kill_reports_r5: assert property (@(posedge clk) disable iff (rst)
    kill_all |-> !diag_pull_low);
endmodule

// File: tb/led_fault_guard_bench.sv
module led_fault_guard_bench;
  localparam int CLK_P = 10;
  localparam int N = 8;
  localparam int DEB = 4;
  // table entry: [5]=ilim [4]=setback [3]=thermal [2]=chain_open [1]=exp kill [0]=exp diag_pull_low
  localparam logic [5:0] VEC [6] = '{6'b0000_01, 6'b1000_00, 6'b0100_00,
                                     6'b0010_10, 6'b0001_10, 6'b1111_10};

  logic clk = 0, rst = 1;
  logic [N-1:0] open_det = 0, drv_active = '1, pin_grounded = 0;
  logic supply_ok = 0, uvlo = 0, latch_sel_n = 0, enable_n = 0, sense = 0;
  logic ilim = 0, setback = 0, thermal = 0, chain = 0;
  logic kill_all, diag_pull_low;
  logic [N-1:0] unused_mask;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  led_fault_guard #(.N_CH(N), .DEB_CYCLES(DEB)) u_led_fault_guard (
    .clk(clk), .rst(rst), .open_det(open_det), .drv_active(drv_active),
    .pin_grounded(pin_grounded), .supply_ok(supply_ok), .uvlo(uvlo),
    .latch_sel_n(latch_sel_n), .enable_n(enable_n), .diag_rst_sense(sense),
    .ref_ilim(ilim), .ov_setback(setback), .therm_sd(thermal), .chain_open(chain),
    .kill_all(kill_all), .diag_pull_low(diag_pull_low), .unused_mask(unused_mask)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(3);
    // R1 reset state
    chk("R1 kill", kill_all, 0);
    chk("R1 diag", diag_pull_low, 1);
    chk("R1 unused", unused_mask, 0);
    rst = 0;
    tick(1);
    chk("R1 kill after release", kill_all, 0);
    supply_ok = 1;
    tick(1);

    // R10 global flag table
    latch_sel_n = 1;
    for (int k = 0; k < 6; k++) begin
      {ilim, setback, thermal, chain} = VEC[k][5:2];
      tick(1);
      chk("R10 kill", kill_all, VEC[k][1]);
      chk("R10 diag", diag_pull_low, VEC[k][0]);
    end
    {ilim, setback, thermal, chain} = 0;
    latch_sel_n = 0;
    tick(1);

    // R3 supply not ready / undervoltage
    supply_ok = 0; open_det = '1;
    tick(8);
    chk("R3 low supply kill", kill_all, 0);
    chk("R3 low supply diag", diag_pull_low, 1);
    supply_ok = 1; uvlo = 1;
    tick(8);
    chk("R3 uvlo kill", kill_all, 0);
    open_det = 0; uvlo = 0;
    tick(1);

    // R2 debounce: interrupted count, then drive-off hold
    open_det = 8'h01; tick(3);
    open_det = 0;     tick(1);
    open_det = 8'h01; tick(3);
    chk("R2 interrupted", kill_all, 0);
    open_det = 0;     tick(1);
    open_det = 8'h01; tick(2);
    drv_active = 0;   tick(3);
    drv_active = '1;  tick(2);
    chk("R2 not yet", kill_all, 0);
    tick(1);
    chk("R2 accepted kill", kill_all, 1);
    chk("R5 diag released", diag_pull_low, 0);

    // R5 latch holds after open clears
    open_det = 0; tick(5);
    chk("R5 held kill", kill_all, 1);
    chk("R5 held diag", diag_pull_low, 0);

    // R7 reset sense edge clears
    sense = 1; tick(1);
    chk("R7 cleared kill", kill_all, 0);
    chk("R7 cleared diag", diag_pull_low, 1);
    sense = 0; open_det = 8'h01; tick(DEB + 1);
    chk("R7 relatched", kill_all, 1);
    sense = 1; tick(1);
    chk("R7 edge clears", kill_all, 0);
    tick(DEB + 1);
    chk("R7 held sense relatch", kill_all, 1);
    sense = 0; open_det = 0; tick(1);

    // R8 enable toggle clears
    enable_n = 1; tick(1);
    chk("R8 toggle clears", kill_all, 0);
    enable_n = 0; tick(1);

    // R9 undervoltage clears
    open_det = 8'h01; tick(DEB + 1);
    open_det = 0; tick(1);
    chk("R9 latched", kill_all, 1);
    uvlo = 1; tick(1);
    chk("R9 uvlo clears", kill_all, 0);
    uvlo = 0; tick(1);

    // R6 report-only mode follows drive phase
    latch_sel_n = 1; open_det = 8'h04; tick(DEB + 1);
    chk("R6 no kill", kill_all, 0);
    chk("R6 report on", diag_pull_low, 0);
    drv_active = 0; tick(1);
    chk("R6 drive off", diag_pull_low, 1);
    drv_active = '1; tick(1);
    chk("R6 drive on again", diag_pull_low, 0);
    open_det = 0; tick(2);
    chk("R6 open gone", diag_pull_low, 1);
    chk("R6 kill stays off", kill_all, 0);

    // R4 unused channel capture and masking
    latch_sel_n = 0; supply_ok = 0; pin_grounded = 8'h08; tick(1);
    supply_ok = 1; pin_grounded = 0; tick(2);
    chk("R4 mask captured", unused_mask, 8'h08);
    open_det = 8'h08; tick(8);
    chk("R4 unused ignored", kill_all, 0);
    chk("R4 unused diag", diag_pull_low, 1);
    open_det = 8'h0A; tick(DEB + 1);
    chk("R4 other channel latches", kill_all, 1);
    chk("R4 mask frozen", unused_mask, 8'h08);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule